// File: doc/BRIEF.md
# Synchronous Burst Read Sequencer

This block is the memory-side control for a synchronous burst read from an array of 512K words of 32 bits. A burst begins when the start address is captured on a latch-enable edge. The block then waits a configurable number of clock edges before the first word appears. After that it steps a 19-bit word counter, one word per clock edge, for as long as the host keeps the advance input low. The data leaves the block as a stream: `dout` is the payload and `rdy` is its valid flag. The advance input is the consumer's back-pressure.

Back-pressure works as follows. When advance is low at a sampled edge, the counter moves on one word and a new word is presented. When advance is high at a sampled edge, the current word is held. Advance is then ignored for a configured hold period before it is sampled again. While a word is held, `rdy` is low.

The ready flag can be placed in one of two timings. In the first it marks the cycle that carries the new word. In the second it leads that cycle by one clock. `rdy` has a separate output enable, which models an open-drain pin that floats whenever no burst is active. The storage array is a behavioural stub that returns a computed pattern word for each address.

Top module: `burst_read_seq`

## Requirements
- R1: The active clock edge is the rising edge of `bclk` when `pol_fall`=0 and the falling edge when `pol_fall`=1. All inputs are sampled only on the active edge, and `pol_fall` changes only while reset is asserted.
- R2: With `sel_n` low, the start address is captured on the first active edge that sees `le_n` low after an edge that saw it high. Further edges with `le_n` still low capture nothing. A new high-to-low transition restarts the burst.
- R3: The word at the captured address is loaded at the X-th active edge after the capture edge, where X is the initial latency. `adv_n` has no effect on any edge before that.
- R4: After the first word, an active edge with `adv_n` low increments the word counter by one and loads the word at the new address.
- R5: An active edge with `adv_n` high holds the counter and `dout`. The next Y-1 edges, where Y is the hold latency, also ignore `adv_n`. `adv_n` is sampled again at the Y-th edge after the holding edge.
- R6: When `cfg_rdy_early`=0, `rdy` is high during a clock cycle exactly when `dout` was loaded with a new word at the active edge that began that cycle.
- R7: When `cfg_rdy_early`=1, `rdy` is high during a clock cycle exactly when the next active edge will load a new word, given the present `adv_n`, `le_n` and `sel_n`.
- R8: `rdy_oe` rises after the capture edge and stays high until an active edge sees `sel_n` high, or until reset. While `rdy_oe` is low, `rdy` is low.
- R9: The initial latency, hold latency and ready timing are latched at the capture edge; changes during a burst have no effect on it. A latency value of 0 or 1 is treated as 2, so the legal range is 2 to 7.
- R10: The word counter wraps from address 0x7FFFF to address 0.
- R11: The word stored at address a is the low 32 bits of the concatenation {~a, a}, where a is 19 bits wide.
- R12: While reset is asserted (`rst_n` low, asynchronous), `rdy_oe`=0, `rdy`=0 and `dout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Burst clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pol_fall | input | 1 | 1 selects the falling edge of `bclk` as the active edge |
| sel_n | input | 1 | Device select, active low; high ends the burst |
| le_n | input | 1 | Latch enable, active low |
| addr | input | 19 | Start word address |
| adv_n | input | 1 | Advance, active low (stream back-pressure) |
| cfg_xlat | input | 3 | Initial latency in clock edges |
| cfg_ylat | input | 3 | Hold latency in clock edges |
| cfg_rdy_early | input | 1 | 1 makes `rdy` lead the data by one cycle |
| dout | output | 32 | Data word |
| rdy | output | 1 | Data valid flag |
| rdy_oe | output | 1 | Output enable of `rdy` (models the open-drain pin) |

## Verification
The first stimulus is a steady stream with advance held low from the capture edge onward. It shows that the initial wait is counted in edges and is not shortened by advance. Isolated and repeated stalls, applied under several hold latencies, show whether advance is really ignored during the hold window and sampled again on the right edge. The same traffic is run with both ready timings and both clock polarities, which separates a ready that is late or early by one cycle from a correct one. A burst started near the top address exercises the counter wrap. A long run with random advance, random restarts and random configuration mixes every transition against a reference model in the bench.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

  // Sequencer phases of one burst
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // no burst, ready floating
    ST_WAIT = 2'd1,  // counting the initial latency
    ST_RUN  = 2'd2,  // advance sampled every edge
    ST_HOLD = 2'd3   // stalled, advance ignored
  } seq_st_t;

  // Smallest latency the counters accept
  localparam int unsigned MIN_LAT = 2;

endpackage

// File: rtl/bsq_capture.sv
// Detects the address capture edge and latches the burst configuration.
module bsq_capture
  import bsq_pkg::*;
#(
  parameter int unsigned LAT_W = 3
) (
  input  logic             aclk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             le_n,
  input  logic [LAT_W-1:0] cfg_xlat,
  input  logic [LAT_W-1:0] cfg_ylat,
  input  logic             cfg_rdy_early,
  output logic             capture,
  output logic [LAT_W-1:0] xl_now,
  output logic [LAT_W-1:0] yl_q,
  output logic             early_q
);

  localparam logic [LAT_W-1:0] LAT_FLOOR = LAT_W'(MIN_LAT);

  logic             le_prev;
  logic [LAT_W-1:0] yl_now;

  // first edge of a low latch-enable run
  assign capture = !sel_n && !le_n && le_prev;

  assign xl_now = (cfg_xlat < LAT_FLOOR) ? LAT_FLOOR : cfg_xlat;
  assign yl_now = (cfg_ylat < LAT_FLOOR) ? LAT_FLOOR : cfg_ylat;

  always_ff @(posedge aclk or negedge rst_n) begin
    if (!rst_n) begin
      le_prev <= 1'b1;
      yl_q    <= LAT_FLOOR;
      early_q <= 1'b0;
    end else begin
      le_prev <= le_n;
      if (capture) begin
        yl_q    <= yl_now;
        early_q <= cfg_rdy_early;
      end
    end
  end

endmodule

// File: rtl/bsq_ctrl.sv
// Burst state machine: latency counting, word stepping and ready generation.
module bsq_ctrl
  import bsq_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned LAT_W  = 3
) (
  input  logic              aclk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adv_n,
  input  logic [LAT_W-1:0]  xl_now,
  input  logic [LAT_W-1:0]  yl_q,
  input  logic              early_q,
  output logic              ld,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rdy,
  output logic              rdy_oe,
  output seq_st_t           st_q,
  output logic [ADDR_W-1:0] addr_q
);

  localparam logic [LAT_W-1:0]  CNT_ONE  = LAT_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  seq_st_t           st_d;
  logic [LAT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_d;
  logic              valid_q, valid_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    addr_d  = addr_q;
    valid_d = 1'b0;
    ld      = 1'b0;
    rd_addr = addr_q;
    if (sel_n) begin
      st_d = ST_IDLE;
    end else if (capture) begin
      st_d   = ST_WAIT;
      cnt_d  = xl_now;
      addr_d = addr;
    end else begin
      unique case (st_q)
        ST_WAIT: begin
          if (cnt_q == CNT_ONE) begin
            st_d    = ST_RUN;
            ld      = 1'b1;
            valid_d = 1'b1;
          end else begin
            cnt_d = cnt_q - CNT_ONE;
          end
        end
        ST_RUN: begin
          if (!adv_n) begin
            addr_d  = addr_q + ADDR_ONE;
            rd_addr = addr_d;
            ld      = 1'b1;
            valid_d = 1'b1;
          end else begin
            st_d  = ST_HOLD;
            cnt_d = yl_q - CNT_ONE;
          end
        end
        ST_HOLD: begin
          cnt_d = cnt_q - CNT_ONE;
          if (cnt_q == CNT_ONE) st_d = ST_RUN;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge aclk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      addr_q  <= addr_d;
      valid_q <= valid_d;
    end
  end

  // lookahead timing uses the decision about to be taken at the next edge
  assign rdy    = early_q ? valid_d : valid_q;
  assign rdy_oe = (st_q != ST_IDLE);

endmodule

// File: rtl/bsq_array.sv
// Behavioural read-only array stub with a registered read port.
module bsq_array #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 32
) (
  input  logic              aclk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] dout
);

  localparam int unsigned PAT_W = 2 * ADDR_W;

  logic [PAT_W-1:0]  pat;
  logic [DATA_W-1:0] word;

  assign pat = {~rd_addr, rd_addr};

  generate
    if (DATA_W <= PAT_W) begin : g_trunc
      assign word = pat[DATA_W-1:0];
    end else begin : g_ext
      assign word = {{(DATA_W - PAT_W){1'b0}}, pat};
    end
  endgenerate

  always_ff @(posedge aclk or negedge rst_n) begin
    if (!rst_n)  dout <= '0;
    else if (ld) dout <= word;
  end

endmodule

// File: rtl/burst_read_seq.sv
// Top of the synchronous burst read sequencer.
module burst_read_seq
  import bsq_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LAT_W  = 3
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              pol_fall,
  input  logic              sel_n,
  input  logic              le_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adv_n,
  input  logic [LAT_W-1:0]  cfg_xlat,
  input  logic [LAT_W-1:0]  cfg_ylat,
  input  logic              cfg_rdy_early,
  output logic [DATA_W-1:0] dout,
  output logic              rdy,
  output logic              rdy_oe
);

  logic              aclk;
  logic              capture;
  logic [LAT_W-1:0]  xl_now;
  logic [LAT_W-1:0]  yl_q;
  logic              early_q;
  logic              ld;
  logic [ADDR_W-1:0] rd_addr;
  logic [ADDR_W-1:0] addr_q;
  seq_st_t           st_q;

  // polarity strap turns the selected edge of bclk into a rising edge
  assign aclk = bclk ^ pol_fall;

  bsq_capture #(.LAT_W(LAT_W)) u_cap (
    .aclk          (aclk),
    .rst_n         (rst_n),
    .sel_n         (sel_n),
    .le_n          (le_n),
    .cfg_xlat      (cfg_xlat),
    .cfg_ylat      (cfg_ylat),
    .cfg_rdy_early (cfg_rdy_early),
    .capture       (capture),
    .xl_now        (xl_now),
    .yl_q          (yl_q),
    .early_q       (early_q)
  );

  bsq_ctrl #(.ADDR_W(ADDR_W), .LAT_W(LAT_W)) u_ctrl (
    .aclk    (aclk),
    .rst_n   (rst_n),
    .sel_n   (sel_n),
    .capture (capture),
    .addr    (addr),
    .adv_n   (adv_n),
    .xl_now  (xl_now),
    .yl_q    (yl_q),
    .early_q (early_q),
    .ld      (ld),
    .rd_addr (rd_addr),
    .rdy     (rdy),
    .rdy_oe  (rdy_oe),
    .st_q    (st_q),
    .addr_q  (addr_q)
  );

  bsq_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .aclk    (aclk),
    .rst_n   (rst_n),
    .ld      (ld),
    .rd_addr (rd_addr),
    .dout    (dout)
  );

endmodule

// File: rtl/bsq_checks.sv
// Temporal properties of the sequencer, bound into the top module.
module bsq_checks
  import bsq_pkg::*;
#(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned DATA_W = 32
) (
  input logic              aclk,
  input logic              rst_n,
  input logic              sel_n,
  input logic              adv_n,
  input logic              capture,
  input logic              early,
  input logic              rdy,
  input logic              rdy_oe,
  input logic [DATA_W-1:0] dout,
  input logic [ADDR_W-1:0] addr_q,
  input seq_st_t           st
);

  // R3: the counter stays put while the initial latency runs
  p_wait_frozen_r3: assert property (@(posedge aclk) disable iff (!rst_n)
    (st == ST_WAIT && !sel_n && !capture) |=> $stable(addr_q));

  // R4: a sampled advance moves the counter by exactly one word
  p_step_one_r4: assert property (@(posedge aclk) disable iff (!rst_n)
    (st == ST_RUN && !sel_n && !capture && !adv_n)
      |=> (addr_q == $past(addr_q) + ADDR_W'(1)));

  // R6: in the aligned timing a low ready means the word did not change
  p_hold_stable_r6: assert property (@(posedge aclk) disable iff (!rst_n)
    (rdy_oe && !rdy && !early) |-> $stable(dout));

  // R7: in the lookahead timing a high ready is followed by a new word
  p_early_lead_r7: assert property (@(posedge aclk) disable iff (!rst_n)
    (st == ST_RUN && rdy && early && !sel_n) |=> !$stable(dout));

  // R8: deselect releases the ready pin on the next cycle
  p_oe_release_r8: assert property (@(posedge aclk) disable iff (!rst_n)
    sel_n |=> !rdy_oe);

  // R8: ready is never driven high while its pin is released
  p_quiet_idle_r8: assert property (@(posedge aclk) disable iff (!rst_n)
    !rdy_oe |-> !rdy);

endmodule

bind burst_read_seq bsq_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .aclk    (aclk),
  .rst_n   (rst_n),
  .sel_n   (sel_n),
  .adv_n   (adv_n),
  .capture (capture),
  .early   (early_q),
  .rdy     (rdy),
  .rdy_oe  (rdy_oe),
  .dout    (dout),
  .addr_q  (addr_q),
  .st      (st_q)
);

// File: tb/burst_read_seq_test.sv
module burst_read_seq_test;

  logic        bclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pol_fall = 1'b0;
  logic        sel_n = 1'b1;
  logic        le_n = 1'b1;
  logic [18:0] addr = '0;
  logic        adv_n = 1'b1;
  logic [2:0]  cfg_xlat = 3'd3;
  logic [2:0]  cfg_ylat = 3'd2;
  logic        cfg_rdy_early = 1'b0;
  logic [31:0] dout;
  logic        rdy;
  logic        rdy_oe;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R12";

  always #4 bclk = ~bclk;  // 125 MHz

  wire aclk_tb = bclk ^ pol_fall;

  burst_read_seq uut (
    .bclk(bclk), .rst_n(rst_n), .pol_fall(pol_fall), .sel_n(sel_n),
    .le_n(le_n), .addr(addr), .adv_n(adv_n), .cfg_xlat(cfg_xlat),
    .cfg_ylat(cfg_ylat), .cfg_rdy_early(cfg_rdy_early),
    .dout(dout), .rdy(rdy), .rdy_oe(rdy_oe)
  );

  typedef struct {
    logic        oe;
    logic        rd;
    logic [31:0] d;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // reference model state: 0 idle, 1 wait, 2 run, 3 hold
  int          m_st, m_age, m_x, m_y;
  bit          m_early, m_valid, m_leprev;
  logic [18:0] m_addr;
  logic [31:0] m_dout;

  function automatic int lat_fix(logic [2:0] v);
    return (v < 3'd2) ? 2 : int'(v);
  endfunction

  function automatic logic [31:0] wrd(logic [18:0] a);
    logic [37:0] p;
    p = {~a, a};
    return p[31:0];
  endfunction

  function automatic bit m_load(bit le, bit adv, bit sel);
    if (sel) return 1'b0;
    if (!le && m_leprev) return 1'b0;
    if (m_st == 1) return (m_age + 1 == m_x);
    if (m_st == 2) return !adv;
    return 1'b0;
  endfunction

  task automatic m_edge(bit le, bit adv, bit sel);
    bit ld;
    ld = m_load(le, adv, sel);
    if (sel) m_st = 0;
    else if (!le && m_leprev) begin
      m_st = 1; m_age = 0;
      m_x = lat_fix(cfg_xlat); m_y = lat_fix(cfg_ylat);
      m_early = cfg_rdy_early; m_addr = addr;
    end else begin
      case (m_st)
        1: begin
          m_age++;
          if (ld) begin m_dout = wrd(m_addr); m_st = 2; end
        end
        2: begin
          if (ld) begin m_addr = m_addr + 19'd1; m_dout = wrd(m_addr); end
          else begin m_st = 3; m_age = 0; end
        end
        3: begin
          m_age++;
          if (m_age == m_y - 1) m_st = 2;
        end
        default: ;
      endcase
    end
    m_valid = ld;
    m_leprev = le;
  endtask

  task automatic m_reset();
    m_st = 0; m_age = 0; m_x = 2; m_y = 2;
    m_early = 0; m_valid = 0; m_leprev = 1; m_addr = '0; m_dout = '0;
  endtask

  // driver: applies inputs for the coming edge and queues this cycle's outputs
  task automatic tick(bit le, bit adv, bit sel);
    exp_t e;
    le_n = le; adv_n = adv; sel_n = sel;
    e.oe  = (m_st != 0);
    e.rd  = m_early ? m_load(le, adv, sel) : m_valid;
    e.d   = m_dout;
    e.tag = cur_tag;
    sb.push_back(e);
    @(posedge aclk_tb);
    m_edge(le, adv, sel);
    #1;
  endtask

  // monitor: compares mid-cycle, away from the active edge
  initial begin
    forever begin
      @(posedge aclk_tb);
      #3;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (rdy_oe !== e.oe || rdy !== e.rd || dout !== e.d) begin
          errors++;
          $display("FAIL %s: oe/rdy/dout got %0b/%0b/%h expected %0b/%0b/%h",
                   e.tag, rdy_oe, rdy, dout, e.oe, e.rd, e.d);
        end
      end
    end
  end

  task automatic do_reset(bit pol);
    rst_n = 1'b0; sel_n = 1'b1; le_n = 1'b1; adv_n = 1'b1;
    #2 pol_fall = pol;
    repeat (3) @(posedge aclk_tb);
    // R12: reset state at the ports
    checks++;
    if (rdy_oe !== 1'b0 || rdy !== 1'b0 || dout !== 32'h0) begin
      errors++;
      $display("FAIL R12: oe/rdy/dout got %0b/%0b/%h expected 0/0/00000000",
               rdy_oe, rdy, dout);
    end
    #1 rst_n = 1'b1;
    sb.delete();
    m_reset();
  endtask

  task automatic start(logic [18:0] a);
    tick(1, 1, 0);
    addr = a;
    tick(0, 1, 0);  // capture edge
  endtask

  task automatic run_basic(logic [18:0] a);
    cfg_xlat = 3'd3; cfg_ylat = 3'd2;
    tick(1, 0, 0);
    addr = a;
    cur_tag = "R3";
    tick(0, 0, 0);               // capture, advance low but ignored
    repeat (3) tick(0, 0, 0);
    cur_tag = "R4";
    repeat (5) tick(0, 0, 0);
    cur_tag = "R5";
    tick(0, 1, 0);
    repeat (3) tick(0, 0, 0);
    tick(0, 1, 0); tick(0, 1, 0); tick(0, 1, 0);
    repeat (3) tick(0, 0, 0);
    tick(1, 1, 1);
  endtask

  initial begin
    m_reset();
    do_reset(1'b0);

    // R6 / R11: aligned ready timing, steady and stalled traffic
    cur_tag = "R11";
    cfg_rdy_early = 1'b0;
    run_basic(19'h00100);
    cur_tag = "R6";
    run_basic(19'h12345);

    // R5: longer hold latency with dense stalls
    cur_tag = "R5";
    cfg_ylat = 3'd4;
    tick(1, 0, 0); addr = 19'h0ABCD; tick(0, 0, 0);
    repeat (3) tick(0, 0, 0);
    for (int i = 0; i < 24; i++) tick(0, (i % 3 == 0), 0);
    tick(1, 1, 1);

    // R7: lookahead ready timing
    cfg_rdy_early = 1'b1;
    cur_tag = "R7";
    run_basic(19'h04000);
    cfg_rdy_early = 1'b0;

    // R1: falling active edge, both ready timings
    do_reset(1'b1);
    cur_tag = "R1";
    run_basic(19'h20000);
    cfg_rdy_early = 1'b1;
    run_basic(19'h31000);
    cfg_rdy_early = 1'b0;
    do_reset(1'b0);

    // R10: wrap at the top of the array
    cur_tag = "R10";
    cfg_xlat = 3'd2;
    start(19'h7FFFE);
    repeat (6) tick(0, 0, 0);
    tick(1, 1, 1);

    // R9: clamped latencies, mid-burst configuration changes ignored
    cur_tag = "R9";
    cfg_xlat = 3'd1; cfg_ylat = 3'd0;
    start(19'h00777);
    cfg_xlat = 3'd7; cfg_ylat = 3'd7; cfg_rdy_early = 1'b1;
    repeat (3) tick(0, 0, 0);
    tick(0, 1, 0);
    repeat (4) tick(0, 0, 0);
    tick(1, 1, 1);
    cfg_rdy_early = 1'b0;

    // R2: held latch enable captures once, a fresh transition restarts
    cur_tag = "R2";
    cfg_xlat = 3'd4; cfg_ylat = 3'd2;
    start(19'h01000);
    addr = 19'h05555;
    repeat (6) tick(0, 0, 0);
    tick(1, 0, 0);
    tick(0, 0, 0);               // restart at 0x05555
    repeat (6) tick(0, 0, 0);

    // R8: deselect releases ready; select with latch enable already low is idle
    cur_tag = "R8";
    tick(0, 0, 1);
    tick(0, 0, 1);
    repeat (4) tick(0, 0, 0);
    tick(1, 0, 0);
    tick(0, 0, 0);
    repeat (5) tick(0, 0, 0);
    tick(1, 1, 1);

    // R5: random advance, restarts and configuration
    cur_tag = "R5";
    for (int i = 0; i < 500; i++) begin
      bit le_v, sel_v;
      if ($urandom_range(0, 30) == 0) begin
        cfg_xlat = 3'($urandom_range(0, 7));
        cfg_ylat = 3'($urandom_range(0, 7));
        cfg_rdy_early = 1'($urandom_range(0, 1));
        addr = 19'($urandom);
        le_v = 1'b1;
      end else le_v = (le_n == 1'b1 && $urandom_range(0, 1) == 1) ? 1'b0 : le_n;
      sel_v = ($urandom_range(0, 60) == 0);
      tick(le_v, 1'($urandom_range(0, 2) == 0), sel_v);
    end
    tick(1, 1, 1);
    tick(1, 1, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule